// File: doc/BRIEF.md
# Two-Dimensional DMA Address Sequencer

This block generates the word addresses for one DMA channel. It covers a rectangular region one line at a time. Each line is a run of consecutive 32-bit words. The start of each line is a programmed stride away from the start of the line before it, so the gap between lines can be skipped. Addresses are word addresses: software shifts the byte address right by two before it loads the base. Loading the base through the start strobe is the last programming step, and that strobe launches the walk. A peripheral acknowledge paces the beats. A beat is taken on every cycle in which the sequencer is presenting a valid address and the acknowledge is high.

A words-per-line value of zero selects ring mode. In ring mode the address climbs through a region of stride × (line field + 1) words and then wraps back to the base. The ring is treated as two equal halves, and a pulse marks the end of each half. The ring keeps running as long as the loop-enable input is high. The block carries no data and decodes no registers: it supplies the address stream, the latched direction and the burst boundaries.

Top module: `dma2d_seq`

## Requirements
- R1: While reset is low, and after it is released, o_valid, o_done and o_half are low and o_addr is 0.
- R2: A start strobe while idle latches every configuration input. On the next cycle o_valid is high and o_addr equals the loaded base. A start strobe while busy is ignored, and so are configuration changes made while busy.
- R3: Within a line, successive beats present consecutive word addresses, and a line holds i_words beats.
- R4: The first beat of each line after the first is at the previous line's first address plus i_stride, whatever the relation between stride and i_words.
- R5: In 2D mode, i_lines = n gives n+1 lines. o_done is high for exactly one cycle, on the cycle after the last beat, and o_valid is low from that same cycle.
- R6: While o_valid is high and i_ack is low, o_addr holds its value and no beat is counted.
- R7: With i_words = 0, the addresses run base, base+1, … up to base + i_stride × (i_lines+1) − 1, and then start again at base.
- R8: In ring mode o_half is high for one cycle after the beat at offset size/2 − 1 and after the beat at offset size − 1 (size is assumed even). It never rises in 2D mode.
- R9: In ring mode no o_done is raised while i_loop_en is high at the end of the region. If i_loop_en is low at that beat, o_done pulses together with o_half and the sequencer goes idle.
- R10: o_dir presents the direction latched at start (1 = memory to peripheral, 0 = peripheral to memory) and stays stable while busy.
- R11: o_burst_last is high on every beat when i_burst = 0. When i_burst = 1 it is high on every fourth beat and also on the last beat of a line (2D mode) or of a half (ring mode). Burst counting restarts after each marked beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_start | input | 1 | Load base and launch (honoured when idle) |
| i_base | input | AW | Start word address (byte address >> 2) |
| i_words | input | LW | Words per line; 0 selects ring mode |
| i_stride | input | LW | Line-to-line distance in words |
| i_lines | input | LW | Number of lines minus one |
| i_dir | input | 1 | 1 memory to peripheral, 0 peripheral to memory |
| i_burst | input | 1 | 1 four-word bursts, 0 single beats |
| i_loop_en | input | 1 | Keep ring mode running at the region end |
| i_ack | input | 1 | Peripheral acknowledge; a beat happens when high with o_valid |
| o_valid | output | 1 | A word address is presented |
| o_addr | output | AW | Current word address |
| o_dir | output | 1 | Latched direction |
| o_burst_last | output | 1 | Current beat closes a burst |
| o_done | output | 1 | One-cycle end-of-transfer pulse |
| o_half | output | 1 | One-cycle end-of-half pulse in ring mode |

## Verification
The address and burst-end flag belong to the beat being offered in the current cycle, so the bench compares them in that same cycle, before the clock edge that accepts the beat. The done and half pulses come from registers loaded by the accepting edge, so they are due one cycle after the beat. The bench samples them at the next falling edge and requires them low everywhere else. A start strobe gives a valid output and the base address one cycle later. Every comparison happens at the falling edge, after inputs for the coming edge have been driven.

// File: rtl/dma2d_pkg.sv
// Shared types for the 2D DMA address sequencer.
package dma2d_pkg;
    // Walk style chosen at start from the words-per-line value
    typedef enum logic {
        WALK_2D   = 1'b0,
        WALK_RING = 1'b1
    } walk_mode_e;
endpackage

// File: rtl/dma2d_step_ctl.sv
// Position counters for the sequencer.
// Tracks word-in-line and line index in 2D mode and the offset into the
// region in ring mode, and flags the segment boundaries of the beat that
// is currently offered. Assumes load and beat are never high together.
module dma2d_step_ctl
    import dma2d_pkg::*;
#(
    parameter int LW = 16,
    parameter int SW = 2 * LW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          beat,
    input  walk_mode_e    mode,
    input  logic [LW-1:0] words,
    input  logic [LW-1:0] lines,
    input  logic [SW-1:0] size,
    input  logic [SW-1:0] half,
    output logic          line_end,
    output logic          last_line,
    output logic          half_end,
    output logic          region_end
);
    localparam logic [LW-1:0] ONE_L = LW'(1);
    localparam logic [SW-1:0] ONE_S = SW'(1);

    logic [LW-1:0] x_q;
    logic [LW-1:0] y_q;
    logic [SW-1:0] off_q;
    logic          first_half_end;

    // Boundary flags of the beat being offered
    always_comb begin
        line_end       = (mode == WALK_2D) && (x_q == words - ONE_L);
        last_line      = (y_q == lines);
        region_end     = (mode == WALK_RING) && (off_q == size - ONE_S);
        first_half_end = (mode == WALK_RING) && (half != '0) && (off_q == half - ONE_S);
        half_end       = first_half_end || region_end;
    end

    // Advance the position on each accepted beat
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            x_q   <= '0;
            y_q   <= '0;
            off_q <= '0;
        end else if (beat) begin
            if (mode == WALK_RING) begin
                off_q <= region_end ? '0 : off_q + ONE_S;
            end else if (line_end) begin
                x_q <= '0;
                y_q <= y_q + ONE_L;
            end else begin
                x_q <= x_q + ONE_L;
            end
        end
    end
endmodule

// File: rtl/dma2d_addr_gen.sv
// Word address register for the sequencer.
// Holds the current address and the first address of the current line.
// It steps by one inside a line, jumps by the stride at a line end, and
// returns to the base at the end of a ring region. Addresses wrap modulo 2^AW.
module dma2d_addr_gen
    import dma2d_pkg::*;
#(
    parameter int AW = 30,
    parameter int LW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_base,
    input  logic [AW-1:0] ring_base,
    input  logic          beat,
    input  walk_mode_e    mode,
    input  logic [LW-1:0] stride,
    input  logic          line_end,
    input  logic          region_end,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] ONE_A = AW'(1);

    logic [AW-1:0] addr_q;
    logic [AW-1:0] line_q;
    logic [AW-1:0] next_line;

    // Start of the following line
    always_comb next_line = line_q + AW'(stride);

    // Address and line-start update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            line_q <= '0;
        end else if (load) begin
            addr_q <= load_base;
            line_q <= load_base;
        end else if (beat) begin
            if (mode == WALK_RING) begin
                addr_q <= region_end ? ring_base : addr_q + ONE_A;
            end else if (line_end) begin
                line_q <= next_line;
                addr_q <= next_line;
            end else begin
                addr_q <= addr_q + ONE_A;
            end
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dma2d_burst_track.sv
// Burst boundary tracker.
// Counts beats inside a burst of BEATS words and marks the beat that closes
// it: every beat in single mode, otherwise the BEATS-th beat or a segment end.
module dma2d_burst_track #(
    parameter int BEATS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic beat,
    input  logic burst_en,
    input  logic seg_end,
    output logic burst_last
);
    localparam int CW = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CW-1:0] TOP = CW'(BEATS - 1);
    localparam logic [CW-1:0] ONE_C = CW'(1);

    logic [CW-1:0] cnt_q;

    // Closing-beat flag for the offered beat
    always_comb burst_last = !burst_en || (cnt_q == TOP) || seg_end;

    // Beat counter inside the current burst
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            cnt_q <= '0;
        end else if (beat) begin
            cnt_q <= burst_last ? '0 : cnt_q + ONE_C;
        end
    end
endmodule

// File: rtl/dma2d_seq.sv
// Two-dimensional DMA address sequencer, top level.
// Latches the channel setup on a start strobe taken while idle. It then
// presents word addresses paced by the peripheral acknowledge and raises
// done / half pulses one cycle after the beat that ends a transfer or a
// ring half. Assumes the ring size is even and at least 2.
module dma2d_seq
    import dma2d_pkg::*;
#(
    parameter int AW    = 30,
    parameter int LW    = 16,
    parameter int BEATS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          i_start,
    input  logic [AW-1:0] i_base,
    input  logic [LW-1:0] i_words,
    input  logic [LW-1:0] i_stride,
    input  logic [LW-1:0] i_lines,
    input  logic          i_dir,
    input  logic          i_burst,
    input  logic          i_loop_en,
    input  logic          i_ack,
    output logic          o_valid,
    output logic [AW-1:0] o_addr,
    output logic          o_dir,
    output logic          o_burst_last,
    output logic          o_done,
    output logic          o_half
);
    localparam int SW = 2 * LW + 1;

    walk_mode_e    mode_q;
    logic          busy_q;
    logic          done_q;
    logic          half_q;
    logic          dir_q;
    logic          burst_q;
    logic [AW-1:0] base_q;
    logic [LW-1:0] words_q;
    logic [LW-1:0] stride_q;
    logic [LW-1:0] lines_q;
    logic [SW-1:0] size_q;
    logic [SW-1:0] halfsz_q;
    logic [SW-1:0] size_d;

    logic accept;
    logic beat;
    logic finish;
    logic ring_mode;
    logic line_end;
    logic last_line;
    logic half_end;
    logic region_end;

    // Handshake decode and end-of-transfer detection
    always_comb begin
        accept    = i_start && !busy_q;
        beat      = busy_q && i_ack;
        ring_mode = (mode_q == WALK_RING);
        size_d    = SW'(i_stride) * (SW'(i_lines) + SW'(1));
        finish    = beat && ((!ring_mode && line_end && last_line) ||
                             (ring_mode && region_end && !i_loop_en));
    end

    // Configuration capture on an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= WALK_2D;
            dir_q    <= 1'b0;
            burst_q  <= 1'b0;
            base_q   <= '0;
            words_q  <= '0;
            stride_q <= '0;
            lines_q  <= '0;
            size_q   <= '0;
            halfsz_q <= '0;
        end else if (accept) begin
            mode_q   <= (i_words == '0) ? WALK_RING : WALK_2D;
            dir_q    <= i_dir;
            burst_q  <= i_burst;
            base_q   <= i_base;
            words_q  <= i_words;
            stride_q <= i_stride;
            lines_q  <= i_lines;
            size_q   <= size_d;
            halfsz_q <= size_d >> 1;
        end
    end

    // Busy state and completion pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            half_q <= 1'b0;
        end else begin
            if (accept)      busy_q <= 1'b1;
            else if (finish) busy_q <= 1'b0;
            done_q <= finish;
            half_q <= beat && half_end;
        end
    end

    dma2d_step_ctl #(.LW(LW), .SW(SW)) u_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .beat       (beat),
        .mode       (mode_q),
        .words      (words_q),
        .lines      (lines_q),
        .size       (size_q),
        .half       (halfsz_q),
        .line_end   (line_end),
        .last_line  (last_line),
        .half_end   (half_end),
        .region_end (region_end)
    );

    dma2d_addr_gen #(.AW(AW), .LW(LW)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .load_base  (i_base),
        .ring_base  (base_q),
        .beat       (beat),
        .mode       (mode_q),
        .stride     (stride_q),
        .line_end   (line_end),
        .region_end (region_end),
        .addr       (o_addr)
    );

    dma2d_burst_track #(.BEATS(BEATS)) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .beat       (beat),
        .burst_en   (burst_q),
        .seg_end    (line_end || half_end),
        .burst_last (o_burst_last)
    );

    assign o_valid = busy_q;
    assign o_dir   = dir_q;
    assign o_done  = done_q;
    assign o_half  = half_q;
endmodule

// File: rtl/dma2d_seq_chk.sv
// Protocol checker for dma2d_seq, attached through bind.
// Observes the top ports plus the latched mode and burst setting.
module dma2d_seq_chk #(
    parameter int AW = 30
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [AW-1:0] base,
    input logic          loop_en,
    input logic          ack,
    input logic          valid,
    input logic [AW-1:0] addr,
    input logic          dir,
    input logic          burst_last,
    input logic          done,
    input logic          half,
    input logic          ring,
    input logic          burst_en
);
    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !valid |=> valid && (addr == $past(base)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !ack |=> valid && $stable(addr));

    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !valid);

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    half_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half |-> ring);

    // R9
    ring_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && ring |-> half && !$past(loop_en));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && $past(valid) |-> $stable(dir));

    // R11
    single_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid && !burst_en |-> burst_last);
endmodule

bind dma2d_seq dma2d_seq_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (i_start),
    .base       (i_base),
    .loop_en    (i_loop_en),
    .ack        (i_ack),
    .valid      (o_valid),
    .addr       (o_addr),
    .dir        (o_dir),
    .burst_last (o_burst_last),
    .done       (o_done),
    .half       (o_half),
    .ring       (ring_mode),
    .burst_en   (burst_q)
);

// File: tb/sim_dma2d_seq.sv
// Directed bench for dma2d_seq: one task per scenario, reference model in the bench.
module sim_dma2d_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 30;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          i_start = 1'b0;
    logic [AW-1:0] i_base = '0;
    logic [LW-1:0] i_words = '0;
    logic [LW-1:0] i_stride = '0;
    logic [LW-1:0] i_lines = '0;
    logic          i_dir = 1'b0;
    logic          i_burst = 1'b0;
    logic          i_loop_en = 1'b1;
    logic          i_ack = 1'b0;
    logic          o_valid;
    logic [AW-1:0] o_addr;
    logic          o_dir;
    logic          o_burst_last;
    logic          o_done;
    logic          o_half;

    int nchk = 0;
    int nerr = 0;
    int cycles = 0;

    dma2d_seq #(.AW(AW), .LW(LW)) u0 (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_base(i_base),
        .i_words(i_words), .i_stride(i_stride), .i_lines(i_lines),
        .i_dir(i_dir), .i_burst(i_burst), .i_loop_en(i_loop_en), .i_ack(i_ack),
        .o_valid(o_valid), .o_addr(o_addr), .o_dir(o_dir),
        .o_burst_last(o_burst_last), .o_done(o_done), .o_half(o_half)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            nchk++;
            nerr++;
            $display("FAIL R5 watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    // Runs one transfer against the bench model; ackmode 0 always, 1 every other, 2 one in three
    task automatic run_xfer(input int base, input int words, input int stride, input int lines,
                            input bit dir, input bit burst, input int ackmode, input int passes,
                            input bit poke);
        bit ring = (words == 0);
        int n_sz = stride * (lines + 1);
        int h_sz = n_sz / 2;
        int total = ring ? n_sz * passes : words * (lines + 1);
        int k = 0, x = 0, y = 0, o = 0, bc = 0, cyc = 0;
        bit exp_done = 0, exp_half = 0, poked = 0;
        @(negedge clk);
        i_base = AW'(base); i_words = LW'(words); i_stride = LW'(stride); i_lines = LW'(lines);
        i_dir = dir; i_burst = burst; i_loop_en = 1'b1; i_ack = 1'b0; i_start = 1'b1;
        @(negedge clk);
        i_start = 1'b0;
        chk("R2", "valid after start", o_valid, 1);
        chk("R2", "addr after start", o_addr, base);
        forever begin
            chk(ring ? "R9" : "R5", "done pulse", o_done, exp_done);
            chk("R8", "half pulse", o_half, exp_half);
            if (k == total) begin
                chk("R5", "idle after end", o_valid, 0);
                break;
            end
            if (cyc > 20000) begin
                chk("R5", "transfer ends", k, total);
                break;
            end
            chk("R2", "valid while busy", o_valid, 1);
            chk("R10", "direction", o_dir, dir);
            if (poke && k == 2 && !poked) begin
                i_start = 1'b1; i_base = AW'(base + 77); i_dir = ~dir;
                i_words = LW'(words + 1); i_stride = LW'(stride + 3);
                poked = 1;
            end
            if (ring) i_loop_en = !(k >= n_sz * (passes - 1));
            i_ack = (ackmode == 0) ? 1'b1 : (ackmode == 1) ? (cyc % 2 == 0) : (cyc % 3 == 0);
            if (ring)
                chk("R7", "ring address", o_addr, base + o);
            else
                chk(!i_ack ? "R6" : (x == 0 && y > 0) ? "R4" : "R3", "line address",
                    o_addr, base + y * stride + x);
            exp_done = 0;
            exp_half = 0;
            if (i_ack) begin
                bit seg = ring ? (o == h_sz - 1 || o == n_sz - 1) : (x == words - 1);
                bit bl = !burst || bc == 3 || seg;
                chk("R11", "burst last", o_burst_last, bl);
                bc = bl ? 0 : bc + 1;
                exp_half = ring && (o == h_sz - 1 || o == n_sz - 1);
                k++;
                exp_done = (k == total);
                if (ring) o = (o == n_sz - 1) ? 0 : o + 1;
                else if (x == words - 1) begin x = 0; y++; end
                else x++;
            end
            cyc++;
            @(negedge clk);
            i_start = 1'b0;
        end
        i_ack = 1'b0;
        i_loop_en = 1'b1;
    endtask

    task automatic test_reset();
        chk("R1", "valid in reset", o_valid, 0);
        chk("R1", "done in reset", o_done, 0);
        chk("R1", "half in reset", o_half, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "valid after reset", o_valid, 0);
        chk("R1", "addr after reset", o_addr, 0);
        chk("R1", "done after reset", o_done, 0);
    endtask

    task automatic test_single_line();   // R5: line field 0 gives one line
        run_xfer(100, 5, 5, 0, 1'b0, 1'b0, 0, 1, 1'b0);
    endtask

    task automatic test_gap_stride();    // R3 R4 R11: stride larger than line, bursts
        run_xfer(1000, 3, 8, 3, 1'b1, 1'b1, 0, 1, 1'b0);
    endtask

    task automatic test_ack_stall();     // R6: stalls hold address; line of 6 in bursts 4+2
        run_xfer(2048, 6, 10, 2, 1'b0, 1'b1, 2, 1, 1'b0);
    endtask

    task automatic test_ring();          // R7 R8 R9: three passes over 16 words
        run_xfer(500, 0, 4, 3, 1'b1, 1'b1, 1, 3, 1'b0);
    endtask

    task automatic test_busy_start();    // R2 R10: start and setup changes while busy ignored
        run_xfer(300, 4, 6, 1, 1'b1, 1'b0, 0, 1, 1'b1);
    endtask

    task automatic test_ring_single();   // R8 R11: single beats, one pass, stop
        run_xfer(64, 0, 2, 1, 1'b0, 1'b0, 0, 1, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        test_single_line();
        test_gap_stride();
        test_ack_stall();
        test_ring();
        test_busy_start();
        test_ring_single();
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule